// File: doc/BRIEF.md
# Single-Bit Test and Modify Unit

This unit executes the four single-bit instructions of a processor datapath: test, test-and-change, test-and-clear and test-and-set. It receives an already fetched destination operand, a bit-number operand, a two-bit operation select and a flag saying whether the destination is a data register (32 bits wide) or a memory byte. One clock later it returns the value to be stored back, the updated condition-code vector, a store-enable and the number of half-cycles the instruction occupies on the bus.

The bit number wraps at the operand width: modulo 32 for a register and modulo 8 for a memory byte. Only the zero flag reflects the test. The other four condition bits pass through untouched. The execution length depends on the operation and grows when the bit number, taken modulo 32, falls in the upper half-word. This holds even for a memory target, whose effective index is below 8.

Top module: `bit_test_modify`

## Requirements
- R1: The effective bit index is `in_src[4:0]` when `in_is_reg` is 1, and `in_src[2:0]` when `in_is_reg` is 0. The higher source bits are ignored.
- R2: `out_ccr[2]` (zero) is 1 when the indexed bit of the original destination was 0, and 0 when it was 1. This applies to every operation.
- R3: For the test operation (`in_op` = 2'b00), `out_result` equals `in_dst`.
- R4: For the clear operation (`in_op` = 2'b10), `out_result` equals `in_dst` with the indexed bit forced to 0.
- R5: For the change operation (`in_op` = 2'b01), `out_result` equals `in_dst` with the indexed bit inverted.
- R6: For the set operation (`in_op` = 2'b11), `out_result` equals `in_dst` with the indexed bit forced to 1.
- R7: When `in_is_reg` is 0, `out_result[31:8]` equals `in_dst[31:8]`.
- R8: Clear reports 8 half-cycles, or 12 when `in_src[4]` is 1.
- R9: Change and set report 4 half-cycles, or 8 when `in_src[4]` is 1. Test reports 0.
- R10: `out_store` is 1 for clear, change and set, and 0 for test.
- R11: `out_ccr` bits 4 (extend), 3 (negative), 1 (overflow) and 0 (carry) equal the matching bits of `in_ccr`.
- R12: The outputs for a request appear on the clock edge after `in_valid` is sampled high, together with `out_valid` = 1. While `rst_n` is low, `out_valid`, `out_result`, `out_ccr`, `out_cycles` and `out_store` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| in_op | input | 2 | 00 test, 01 change, 10 clear, 11 set |
| in_dst | input | 32 | Destination operand |
| in_src | input | 32 | Bit-number operand |
| in_is_reg | input | 1 | 1: register target, 0: memory byte target |
| in_ccr | input | 5 | Incoming condition bits {X,N,Z,V,C} |
| out_valid | output | 1 | Result valid |
| out_result | output | 32 | Value to store back |
| out_ccr | output | 5 | Condition bits with the zero flag updated |
| out_cycles | output | 5 | Execution length in half-cycles |
| out_store | output | 1 | Destination must be written back |

## Verification
The assertions check every valid result against the request of the cycle before. They cover the zero flag, the unchanged destination for test, the limit of one changed bit, the preserved upper bytes of a memory target, the pass-through condition bits, the store-enable and both timing formulas. The bench's scenarios are needed to show the exact bit that clear, change and set modify. They also cover wrap-around of large bit numbers such as 33 or 255, and the case of a memory target whose source bit number lies in the upper half-word: its effective index is below 8, yet it still pays the extra four half-cycles.

// File: rtl/bitop_pkg.sv
package bitop_pkg;

    typedef enum logic [1:0] {
        BOP_TEST = 2'b00,
        BOP_CHG  = 2'b01,
        BOP_CLR  = 2'b10,
        BOP_SET  = 2'b11
    } bop_e;

    localparam int CCR_W = 5;
    localparam int CCR_X = 4;
    localparam int CCR_N = 3;
    localparam int CCR_Z = 2;
    localparam int CCR_V = 1;
    localparam int CCR_C = 0;

endpackage

// File: rtl/bitop_index.sv
module bitop_index #(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SRC_W  = 32,
    localparam int IDX_W  = $clog2(DATA_W),
    localparam int MIDX_W = $clog2(MEM_W)
) (
    input  logic [SRC_W-1:0]  src,
    input  logic              is_reg,
    output logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] onehot,
    output logic              upper_half
);

    always_comb begin
        if (is_reg) begin
            idx = src[IDX_W-1:0];
        end else begin
            idx = {{(IDX_W-MIDX_W){1'b0}}, src[MIDX_W-1:0]};
        end
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_dec
        assign onehot[g] = (idx == IDX_W'(g));
    end

    // The length rule looks at the unmasked number modulo the register width.
    assign upper_half = src[IDX_W-1];

endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8
) (
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] onehot,
    input  bop_e              op,
    input  logic              is_reg,
    output logic [DATA_W-1:0] result,
    output logic              was_zero
);

    logic [DATA_W-1:0] modified;

    assign was_zero = ~|(dst & onehot);

    always_comb begin
        unique case (op)
            BOP_CHG: modified = dst ^ onehot;
            BOP_CLR: modified = dst & ~onehot;
            BOP_SET: modified = dst | onehot;
            default: modified = dst;
        endcase
    end

    for (genvar g = 0; g < DATA_W; g++) begin : g_wb
        if (g < MEM_W) begin : g_low
            assign result[g] = modified[g];
        end else begin : g_high
            assign result[g] = is_reg ? modified[g] : dst[g];
        end
    end

endmodule

// File: rtl/bitop_timing.sv
module bitop_timing
    import bitop_pkg::*;
#(
    parameter int CYC_W     = 5,
    parameter int TEST_BASE = 0,
    parameter int MOD_BASE  = 4,
    parameter int CLR_BASE  = 8,
    parameter int HI_EXTRA  = 4
) (
    input  bop_e             op,
    input  logic             upper_half,
    output logic [CYC_W-1:0] cycles
);

    logic [CYC_W-1:0] base;
    logic [CYC_W-1:0] extra;

    always_comb begin
        unique case (op)
            BOP_CLR:         base = CYC_W'(CLR_BASE);
            BOP_CHG, BOP_SET: base = CYC_W'(MOD_BASE);
            default:         base = CYC_W'(TEST_BASE);
        endcase
        extra  = (op != BOP_TEST && upper_half) ? CYC_W'(HI_EXTRA) : '0;
        cycles = base + extra;
    end

endmodule

// File: rtl/bit_test_modify.sv
module bit_test_modify
    import bitop_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SRC_W  = 32,
    parameter int CYC_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        in_op,
    input  logic [DATA_W-1:0] in_dst,
    input  logic [SRC_W-1:0]  in_src,
    input  logic              in_is_reg,
    input  logic [CCR_W-1:0]  in_ccr,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_result,
    output logic [CCR_W-1:0]  out_ccr,
    output logic [CYC_W-1:0]  out_cycles,
    output logic              out_store
);

    localparam int IDX_W = $clog2(DATA_W);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] result;
        logic [CCR_W-1:0]  ccr;
        logic [CYC_W-1:0]  cycles;
        logic              store;
    } stage_t;

    stage_t stage_d, stage_q;

    bop_e              op_sel;
    logic [IDX_W-1:0]  bit_idx;
    logic [DATA_W-1:0] bit_mask;
    logic              hi_half;
    logic [DATA_W-1:0] alu_result;
    logic              alu_zero;
    logic [CYC_W-1:0]  len_hc;

    assign op_sel = bop_e'(in_op);

    bitop_index #(
        .DATA_W (DATA_W),
        .MEM_W  (MEM_W),
        .SRC_W  (SRC_W)
    ) i_index (
        .src        (in_src),
        .is_reg     (in_is_reg),
        .idx        (bit_idx),
        .onehot     (bit_mask),
        .upper_half (hi_half)
    );

    bitop_alu #(
        .DATA_W (DATA_W),
        .MEM_W  (MEM_W)
    ) i_alu (
        .dst      (in_dst),
        .onehot   (bit_mask),
        .op       (op_sel),
        .is_reg   (in_is_reg),
        .result   (alu_result),
        .was_zero (alu_zero)
    );

    bitop_timing #(
        .CYC_W (CYC_W)
    ) i_timing (
        .op         (op_sel),
        .upper_half (hi_half),
        .cycles     (len_hc)
    );

    always_comb begin
        stage_d            = stage_q;
        stage_d.valid      = in_valid;
        if (in_valid) begin
            stage_d.result     = alu_result;
            stage_d.ccr        = in_ccr;
            stage_d.ccr[CCR_Z] = alu_zero;
            stage_d.cycles     = len_hc;
            stage_d.store      = (op_sel != BOP_TEST);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid  = stage_q.valid;
    assign out_result = stage_q.result;
    assign out_ccr    = stage_q.ccr;
    assign out_cycles = stage_q.cycles;
    assign out_store  = stage_q.store;

    logic unused_idx;
    assign unused_idx = ^bit_idx;

endmodule

// File: rtl/bit_test_modify_chk.sv
module bit_test_modify_chk #(
    parameter int DATA_W = 32,
    parameter int MEM_W  = 8,
    parameter int SRC_W  = 32,
    parameter int CYC_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [1:0]        in_op,
    input logic [DATA_W-1:0] in_dst,
    input logic [SRC_W-1:0]  in_src,
    input logic              in_is_reg,
    input logic [4:0]        in_ccr,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_result,
    input logic [4:0]        out_ccr,
    input logic [CYC_W-1:0]  out_cycles,
    input logic              out_store
);

    localparam int IDX_W  = $clog2(DATA_W);
    localparam int MIDX_W = $clog2(MEM_W);

    logic [IDX_W-1:0] chk_idx;
    logic             chk_bit;
    logic [4:0]       chk_len;

    always_comb begin
        chk_idx = in_is_reg ? in_src[IDX_W-1:0]
                            : IDX_W'(in_src[MIDX_W-1:0]);
        chk_bit = in_dst[chk_idx];
        case (in_op)
            2'b10:   chk_len = in_src[IDX_W-1] ? 5'd12 : 5'd8;
            2'b01,
            2'b11:   chk_len = in_src[IDX_W-1] ? 5'd8 : 5'd4;
            default: chk_len = 5'd0;
        endcase
    end

    assert_zero_flag_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_ccr[2] == !$past(chk_bit));

    assert_test_keeps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(in_op) == 2'b00) |-> out_result == $past(in_dst));

    assert_single_bit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_result ^ $past(in_dst)) <= 1);

    assert_mem_upper_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !$past(in_is_reg)) |->
            out_result[DATA_W-1:MEM_W] == $past(in_dst[DATA_W-1:MEM_W]));

    assert_flags_pass_R11: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ({out_ccr[4:3], out_ccr[1:0]} ==
                       $past({in_ccr[4:3], in_ccr[1:0]})));

    assert_store_en_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_store == ($past(in_op) != 2'b00));

    assert_length_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_cycles == CYC_W'($past(chk_len)));

    assert_latency_R12: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));

endmodule

bind bit_test_modify bit_test_modify_chk #(
    .DATA_W (DATA_W),
    .MEM_W  (MEM_W),
    .SRC_W  (SRC_W),
    .CYC_W  (CYC_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_op      (in_op),
    .in_dst     (in_dst),
    .in_src     (in_src),
    .in_is_reg  (in_is_reg),
    .in_ccr     (in_ccr),
    .out_valid  (out_valid),
    .out_result (out_result),
    .out_ccr    (out_ccr),
    .out_cycles (out_cycles),
    .out_store  (out_store)
);

// File: tb/test_bit_test_modify.sv
module test_bit_test_modify;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  in_op = 2'b00;
    logic [31:0] in_dst = '0;
    logic [31:0] in_src = '0;
    logic        in_is_reg = 1'b0;
    logic [4:0]  in_ccr = '0;
    logic        out_valid;
    logic [31:0] out_result;
    logic [4:0]  out_ccr;
    logic [4:0]  out_cycles;
    logic        out_store;

    int n_checks = 0;
    int n_bad = 0;

    typedef struct {
        bit          valid;
        bit          is_reg;
        int          op;
        logic [31:0] dst;
        logic [31:0] result;
        logic [4:0]  ccr;
        int          cycles;
        bit          store;
    } exp_t;

    exp_t exp_q[$];

    always #2 clk = ~clk;

    bit_test_modify i_bit_test_modify (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_op      (in_op),
        .in_dst     (in_dst),
        .in_src     (in_src),
        .in_is_reg  (in_is_reg),
        .in_ccr     (in_ccr),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_ccr    (out_ccr),
        .out_cycles (out_cycles),
        .out_store  (out_store)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    function automatic exp_t model(input bit v, input int op, input logic [31:0] dst,
                                   input logic [31:0] src, input bit is_reg, input logic [4:0] ccr);
        exp_t e;
        int idx;
        bit hi;
        e.valid  = v;
        e.is_reg = is_reg;
        e.op     = op;
        e.dst    = dst;
        idx = is_reg ? int'(src % 32) : int'(src % 8);
        hi  = (src % 32) >= 16;
        e.result = dst;
        if (op == 1) e.result[idx] = ~dst[idx];
        if (op == 2) e.result[idx] = 1'b0;
        if (op == 3) e.result[idx] = 1'b1;
        e.ccr    = ccr;
        e.ccr[2] = (dst[idx] == 1'b0);
        if (op == 0) e.cycles = 0;
        else if (op == 2) e.cycles = hi ? 12 : 8;
        else e.cycles = hi ? 8 : 4;
        e.store = (op != 0);
        return e;
    endfunction

    task automatic compare_one();
        exp_t e;
        string rq;
        if (exp_q.size() == 0) return;
        e = exp_q.pop_front();
        check("R12 valid", 64'(out_valid), 64'(e.valid));
        if (e.valid) begin
            case (e.op)
                0: rq = "R3 R1 result";
                1: rq = "R5 R1 result";
                2: rq = "R4 R1 result";
                default: rq = "R6 R1 result";
            endcase
            check(rq, 64'(out_result), 64'(e.result));
            if (!e.is_reg) check("R7 upper bytes", 64'(out_result[31:8]), 64'(e.dst[31:8]));
            check("R2 zero flag", 64'(out_ccr[2]), 64'(e.ccr[2]));
            check("R11 other flags", 64'({out_ccr[4:3], out_ccr[1:0]}),
                  64'({e.ccr[4:3], e.ccr[1:0]}));
            check(e.op == 2 ? "R8 length" : "R9 length", 64'(out_cycles), 64'(e.cycles));
            check("R10 store", 64'(out_store), 64'(e.store));
        end
    endtask

    task automatic step(input bit v, input int op, input logic [31:0] dst,
                        input logic [31:0] src, input bit is_reg, input logic [4:0] ccr);
        @(negedge clk);
        compare_one();
        in_valid  = v;
        in_op     = 2'(op);
        in_dst    = dst;
        in_src    = src;
        in_is_reg = is_reg;
        in_ccr    = ccr;
        exp_q.push_back(model(v, op, dst, src, is_reg, ccr));
    endtask

    initial begin
        #200000;
        n_checks++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check("R12 reset valid", 64'(out_valid), 64'd0);
        check("R12 reset result", 64'(out_result), 64'd0);
        check("R12 reset ccr", 64'(out_ccr), 64'd0);
        check("R12 reset cycles", 64'(out_cycles), 64'd0);
        check("R12 reset store", 64'(out_store), 64'd0);
        rst_n = 1'b1;

        // Register target, each op, boundaries of the half-word
        step(1, 0, 32'h0000_0001, 32'd0,  1, 5'b11011);
        step(1, 2, 32'hFFFF_FFFF, 32'd31, 1, 5'b00000);
        step(1, 1, 32'h0000_0000, 32'd16, 1, 5'b10101);
        step(1, 3, 32'h0000_0000, 32'd15, 1, 5'b01010);
        step(1, 2, 32'h0000_8000, 32'd15, 1, 5'b11111);
        step(1, 3, 32'h0001_0000, 32'd16, 1, 5'b00100);
        // R1: wrap of large bit numbers
        step(1, 1, 32'h0000_0002, 32'd33,  1, 5'b00000);
        step(1, 3, 32'h0000_0000, 32'd255, 1, 5'b00000);
        // Memory target: modulo 8, upper bytes preserved, length from mod 32
        step(1, 3, 32'hA5A5_A500, 32'd9,  0, 5'b10010);
        step(1, 2, 32'h1234_56FF, 32'd20, 0, 5'b00001);
        step(1, 1, 32'hDEAD_BE00, 32'd7,  0, 5'b01000);
        step(1, 0, 32'hCAFE_F00D, 32'd18, 0, 5'b00000);
        // Idle cycle
        step(0, 3, 32'hFFFF_FFFF, 32'd3, 1, 5'b11111);
        // Random mix
        for (int i = 0; i < 400; i++) begin
            step(($urandom % 5) != 0, int'($urandom % 4), $urandom, $urandom,
                 bit'($urandom % 2), 5'($urandom));
        end
        step(0, 0, 32'd0, 32'd0, 1, 5'd0);
        @(negedge clk);
        compare_one();
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

endmodule